// File: doc/BRIEF.md
# Crystal Oscillator Control Unit

This block is the digital side of a crystal oscillator. It keeps the control, configuration and calibration registers, and it decides from them and from a hardware request line whether the analog core is enabled. Once the core is enabled, the block holds the ready indication low until a programmed number of oscillator ticks has been seen. For a crystal source that count has a floor of 256 ticks.

Software reaches the block through a single-cycle register bus. A configuration write is accepted only while the oscillator is forced off and its enabled status has cleared. A calibration write is accepted only while no earlier calibration write is still being synchronised. A rejected write leaves the register unchanged and raises a bus fault. A key register locks the control, configuration and calibration registers against writes. The analog core receives the enable and the selected source, automatic-gain and tuning values.

Top module: `xo_ctrl`

## Requirements
- R1: After reset, osc_en_o, enabled_o, ready_o and fault_o are 0. The register reads are as follows: control (addr 0) reads 0; configuration (addr 1) reads 0x1000, which is source crystal with timeout 256; lock status (addr 4) reads 0; status (addr 3) reads 0.
- R2: Control bits [1:0] select the enable mode: 0 is on-demand, 1 is forced on, 2 and 3 are forced off. osc_en_o and enabled_o follow the selected mode one clock cycle after the decision input changes. In on-demand mode they follow hw_req_i.
- R3: Control bit 2, when set, blocks hw_req_i, so that on-demand mode does not enable the oscillator.
- R4: ready_o rises on the cycle after the N-th osc_tick_i is sampled while enabled. N is the configuration timeout field (bits [15:4]), with N=0 treated as 1. When the source is crystal, N is raised to at least 256. Ticks sampled while ready_o is 0 and osc_tick_i is 0 are not counted.
- R5: When the oscillator is disabled, ready_o and enabled_o fall together in the same cycle. The startup count restarts, so the next enable waits the full N ticks again, even after a single-cycle disable.
- R6: A configuration write is accepted only when the control mode is forced off (2 or 3) and enabled_o is 0. Any other unlocked configuration write leaves the register unchanged and sets fault_o for the cycle after the write.
- R7: An accepted calibration write (addr 2, bits [7:0]) makes status bit 2 (calibration busy) read 1 for the next 4 cycles. An unlocked calibration write made while busy leaves the register unchanged and sets fault_o.
- R8: A write of exactly 0x1A20 to the lock register bits [15:0] clears the lock. A write of any other value sets it. Lock status is readable as bit 0 of addr 4 and as status bit 3.
- R9: While locked, writes to control, configuration and calibration are ignored and raise no fault. Status and lock reads still work.
- R10: src_o carries configuration bits [1:0] (0 crystal, 1 buffered sine, 2 digital clock). agc_en_o carries configuration bit 2. cal_tune_o carries the calibration value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write when 1 |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| fault_o | output | 1 | Bus fault for the previous cycle's write |
| hw_req_i | input | 1 | Hardware on-demand request |
| osc_tick_i | input | 1 | Oscillator cycle tick, synchronous to clk_i |
| osc_en_o | output | 1 | Enable to the analog core |
| ready_o | output | 1 | Oscillator ready |
| enabled_o | output | 1 | Enabled status |
| src_o | output | 2 | Selected source type |
| agc_en_o | output | 1 | Automatic gain control enable |
| cal_tune_o | output | 8 | Calibration tuning value |

## Verification
The startup delay is checked with a table of source types and timeouts. The table includes a zero timeout, short timeouts on the non-crystal sources, and crystal timeouts below and above the 256 floor. Together these separate a floor applied per source from one applied always or never, and they catch off-by-one counting. Gating of the tick input shows that the delay counts oscillator cycles and not clock cycles. A one-cycle disable shows that the count restarts. Writes are checked in three situations: back-to-back with an enable still draining, with the calibration synchroniser still busy, and under the lock. These separate a fault from a write that is simply ignored.

// File: rtl/xo_ctrl_pkg.sv
package xo_ctrl_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_CFG  = 3'd1,
    A_CAL  = 3'd2,
    A_STAT = 3'd3,
    A_LOCK = 3'd4
  } addr_e;

  typedef enum logic [1:0] {
    EN_DEMAND = 2'd0,
    EN_FON    = 2'd1,
    EN_FOFF   = 2'd2,
    EN_FOFF2  = 2'd3
  } en_mode_e;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_SINE = 2'd1,
    SRC_DIG  = 2'd2,
    SRC_RSV  = 2'd3
  } src_e;

  localparam logic [15:0] UNLOCK_KEY = 16'h1A20;
endpackage

// File: rtl/xo_ctrl_calsync.sv
module xo_ctrl_calsync #(
  parameter int SYNC_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(SYNC_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(SYNC_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R7: accepted write starts the busy window
  a_r7_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R7: register file never accepts while busy
  a_r7_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/xo_ctrl_startup.sv
module xo_ctrl_startup
  import xo_ctrl_pkg::*;
#(
  parameter int TMO_W    = 12,
  parameter int XTAL_MIN = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  en_mode_e         mode_i,
  input  logic             block_hw_i,
  input  logic             hw_req_i,
  input  logic             tick_i,
  input  src_e             src_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             en_o,
  output logic             ready_o
);
  logic             want;
  logic [TMO_W-1:0] floor_v, target;
  logic [TMO_W-1:0] cnt_q;
  logic             en_q, done_q;

  assign want    = (mode_i == EN_FON) ||
                   ((mode_i == EN_DEMAND) && hw_req_i && !block_hw_i);
  assign floor_v = (src_i == SRC_XTAL) ? TMO_W'(XTAL_MIN) : TMO_W'(1);
  assign target  = (tmo_i < floor_v) ? floor_v : tmo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      en_q <= want;
      if (!en_q) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (tick_i && !done_q) begin
        cnt_q  <= cnt_q + 1'b1;
        done_q <= ({1'b0, cnt_q} + 1'b1) >= {1'b0, target};
      end
    end
  end

  assign en_o    = en_q;
  assign ready_o = done_q && en_q;

  // R4: ready only rises on a counted tick
  a_r4_ready_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(tick_i));
  // R5: every fresh enable starts from a cleared count
  a_r5_restart_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> !done_q);
  // R2: forced on enables next cycle
  a_r2_force_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EN_FON) |=> en_o);
  // R2: forced off disables next cycle
  a_r2_force_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == EN_FOFF || mode_i == EN_FOFF2) |=> !en_o);
endmodule

// File: rtl/xo_ctrl_regs.sv
module xo_ctrl_regs
  import xo_ctrl_pkg::*;
#(
  parameter int TMO_W   = 12,
  parameter int CAL_W   = 8,
  parameter int TMO_RST = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              fault_o,
  input  logic              ens_i,
  input  logic              ready_i,
  input  logic              busy_i,
  output en_mode_e          mode_o,
  output logic              block_hw_o,
  output src_e              src_o,
  output logic              agc_o,
  output logic [TMO_W-1:0]  tmo_o,
  output logic [CAL_W-1:0]  cal_o,
  output logic              cal_start_o
);
  localparam int TMO_LSB = 4;

  en_mode_e         mode_q;
  logic             block_q, agc_q, lock_q, fault_q;
  src_e             src_q;
  logic [TMO_W-1:0] tmo_q;
  logic [CAL_W-1:0] cal_q;

  logic wr, hit_ctrl, hit_cfg, hit_cal, hit_lock;
  logic cfg_ok, ctrl_acc, cfg_acc, cfg_bad, cal_acc, cal_bad;

  assign wr       = req_i && we_i;
  assign hit_ctrl = wr && (addr_i == A_CTRL);
  assign hit_cfg  = wr && (addr_i == A_CFG);
  assign hit_cal  = wr && (addr_i == A_CAL);
  assign hit_lock = wr && (addr_i == A_LOCK);

  assign cfg_ok   = ((mode_q == EN_FOFF) || (mode_q == EN_FOFF2)) && !ens_i;
  assign ctrl_acc = hit_ctrl && !lock_q;
  assign cfg_acc  = hit_cfg && !lock_q && cfg_ok;
  assign cfg_bad  = hit_cfg && !lock_q && !cfg_ok;
  assign cal_acc  = hit_cal && !lock_q && !busy_i;
  assign cal_bad  = hit_cal && !lock_q && busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= EN_DEMAND;
      block_q <= 1'b0;
      src_q   <= SRC_XTAL;
      agc_q   <= 1'b0;
      tmo_q   <= TMO_W'(TMO_RST);
      cal_q   <= '0;
      lock_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= cfg_bad || cal_bad;
      if (ctrl_acc) begin
        mode_q  <= en_mode_e'(wdata_i[1:0]);
        block_q <= wdata_i[2];
      end
      if (cfg_acc) begin
        src_q <= src_e'(wdata_i[1:0]);
        agc_q <= wdata_i[2];
        tmo_q <= wdata_i[TMO_LSB +: TMO_W];
      end
      if (cal_acc)  cal_q  <= wdata_i[CAL_W-1:0];
      if (hit_lock) lock_q <= (wdata_i[15:0] != UNLOCK_KEY);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o[2:0] = {block_q, mode_q};
      A_CFG: begin
        rdata_o[1:0]                 = src_q;
        rdata_o[2]                   = agc_q;
        rdata_o[TMO_LSB +: TMO_W]    = tmo_q;
      end
      A_CAL:  rdata_o[CAL_W-1:0] = cal_q;
      A_STAT: rdata_o[3:0] = {lock_q, busy_i, ens_i, ready_i};
      A_LOCK: rdata_o[0]   = lock_q;
      default: rdata_o = '0;
    endcase
  end

  assign fault_o     = fault_q;
  assign mode_o      = mode_q;
  assign block_hw_o  = block_q;
  assign src_o       = src_q;
  assign agc_o       = agc_q;
  assign tmo_o       = tmo_q;
  assign cal_o       = cal_q;
  assign cal_start_o = cal_acc;

  // R6: configuration frozen while the oscillator is enabled
  a_r6_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ens_i |=> ($stable(tmo_q) && $stable(src_q) && $stable(agc_q)));
  // R6: a fault only follows a write
  a_r6_fault_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> $past(wr));
  // R9: locked control writes ignored
  a_r9_locked_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && hit_ctrl) |=> ($stable(mode_q) && $stable(block_q)));
  // R9: locked writes raise no fault
  a_r9_locked_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr) |=> !fault_q);
  // R7: calibration value held while busy
  a_r7_cal_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cal_q));
endmodule

// File: rtl/xo_ctrl.sv
module xo_ctrl
  import xo_ctrl_pkg::*;
#(
  parameter int TMO_W    = 12,
  parameter int CAL_W    = 8,
  parameter int TMO_RST  = 256,
  parameter int XTAL_MIN = 256,
  parameter int SYNC_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             fault_o,
  input  logic             hw_req_i,
  input  logic             osc_tick_i,
  output logic             osc_en_o,
  output logic             ready_o,
  output logic             enabled_o,
  output logic [1:0]       src_o,
  output logic             agc_en_o,
  output logic [CAL_W-1:0] cal_tune_o
);
  en_mode_e         mode;
  src_e             src;
  logic             block_hw, en, rdy, busy, cal_start;
  logic [TMO_W-1:0] tmo;

  xo_ctrl_regs #(.TMO_W(TMO_W), .CAL_W(CAL_W), .TMO_RST(TMO_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .fault_o    (fault_o),
    .ens_i      (en),
    .ready_i    (rdy),
    .busy_i     (busy),
    .mode_o     (mode),
    .block_hw_o (block_hw),
    .src_o      (src),
    .agc_o      (agc_en_o),
    .tmo_o      (tmo),
    .cal_o      (cal_tune_o),
    .cal_start_o(cal_start)
  );

  xo_ctrl_startup #(.TMO_W(TMO_W), .XTAL_MIN(XTAL_MIN)) u_startup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .block_hw_i(block_hw),
    .hw_req_i  (hw_req_i),
    .tick_i    (osc_tick_i),
    .src_i     (src),
    .tmo_i     (tmo),
    .en_o      (en),
    .ready_o   (rdy)
  );

  xo_ctrl_calsync #(.SYNC_CYC(SYNC_CYC)) u_calsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cal_start),
    .busy_o (busy)
  );

  assign osc_en_o  = en;
  assign enabled_o = en;
  assign ready_o   = rdy;
  assign src_o     = src;

  // R5: ready and enabled fall together
  a_r5_drop_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enabled_o) |-> !ready_o);
endmodule

// File: tb/tb_xo_ctrl.sv
module tb_xo_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        fault_o, hw_req_i = 1'b0, osc_tick_i = 1'b1;
  logic        osc_en_o, ready_o, enabled_o, agc_en_o;
  logic [1:0]  src_o;
  logic [7:0]  cal_tune_o;

  int n_run = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  xo_ctrl dut (.*);

  // {src, timeout, expected negedges until ready after the enabling write}
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {2'd2, 12'd5,   16'd6},
    {2'd1, 12'd1,   16'd2},
    {2'd2, 12'd0,   16'd2},
    {2'd0, 12'd10,  16'd257},
    {2'd0, 12'd300, 16'd301},
    {2'd1, 12'd40,  16'd41}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (!ready_o && k < 2000) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  function automatic logic [31:0] cfg_word(input logic [1:0] s, input logic agc, input logic [11:0] t);
    return {16'd0, t, 1'b0, agc, s};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 osc_en", osc_en_o, 0);
    chk("R1 ready", ready_o, 0);
    chk("R1 fault", fault_o, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 cfg", v, 32'h1000);
    rd(3'd4, v); chk("R1 lock", v, 0);
    rd(3'd3, v); chk("R1 status", v, 0);

    // R2 on-demand follows hw request one cycle later
    hw_req_i = 1'b1;
    @(negedge clk_i);
    chk("R2 demand on", osc_en_o, 1);
    // R3 block hardware requests
    wr(3'd0, 32'h4);
    @(negedge clk_i);
    chk("R3 blocked", osc_en_o, 0);
    // R2 mode 3 is forced off
    wr(3'd0, 32'h3);
    @(negedge clk_i);
    chk("R2 mode3 off", enabled_o, 0);
    hw_req_i = 1'b0;

    // R4 / R10 startup table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 32'h2);
      @(negedge clk_i);
      wr(3'd1, cfg_word(VEC[i][29:28], i[0], VEC[i][27:16]));
      chk("R6 cfg accepted no fault", fault_o, 0);
      chk("R10 src", src_o, VEC[i][29:28]);
      chk("R10 agc", agc_en_o, i[0]);
      wr(3'd0, 32'h1);
      wait_ready(k);
      chk("R4 startup delay", k, VEC[i][15:0]);
    end

    // R6 cfg write while still enabled faults; R5 both drop together
    wr(3'd0, 32'h2);
    wr(3'd1, cfg_word(2'd2, 1'b0, 12'd5));
    chk("R6 fault while enabled", fault_o, 1);
    chk("R5 enabled dropped", enabled_o, 0);
    chk("R5 ready dropped", ready_o, 0);
    rd(3'd1, v); chk("R6 cfg unchanged", v, cfg_word(2'd1, 1'b1, 12'd40));

    // R5 restart after one-cycle disable
    wr(3'd1, cfg_word(2'd2, 1'b0, 12'd5));
    chk("R6 cfg ok when off", fault_o, 0);
    wr(3'd0, 32'h1);
    wait_ready(k);
    chk("R4 digital t5", k, 6);
    wr(3'd0, 32'h2);
    wr(3'd0, 32'h1);
    wait_ready(k);
    chk("R5 full wait after glitch", k, 6);

    // R4 ticks gate the count
    wr(3'd0, 32'h2);
    @(negedge clk_i);
    osc_tick_i = 1'b0;
    wr(3'd0, 32'h1);
    repeat (20) @(negedge clk_i);
    chk("R4 no ticks no ready", ready_o, 0);
    chk("R4 enabled without ticks", enabled_o, 1);
    osc_tick_i = 1'b1;
    wait_ready(k);
    chk("R4 counts ticks only", k, 5);

    // R6 cfg write in on-demand mode while disabled still faults
    wr(3'd0, 32'h0);
    @(negedge clk_i);
    wr(3'd1, cfg_word(2'd1, 1'b0, 12'd7));
    chk("R6 fault not forced off", fault_o, 1);
    rd(3'd1, v); chk("R6 cfg kept", v, cfg_word(2'd2, 1'b0, 12'd5));

    // R7 calibration busy
    wr(3'd2, 32'h5A);
    chk("R7 first cal ok", fault_o, 0);
    wr(3'd2, 32'h33);
    chk("R7 busy fault", fault_o, 1);
    chk("R10 cal out", cal_tune_o, 8'h5A);
    rd(3'd3, v); chk("R7 busy status", v[2], 1);
    repeat (4) @(negedge clk_i);
    rd(3'd3, v); chk("R7 busy cleared", v[2], 0);
    wr(3'd2, 32'h33);
    chk("R7 later cal ok", fault_o, 0);
    rd(3'd2, v); chk("R7 cal value", v, 32'h33);

    // R8 / R9 lock
    repeat (5) @(negedge clk_i);
    wr(3'd4, 32'h1234);
    rd(3'd4, v); chk("R8 locked", v, 1);
    rd(3'd3, v); chk("R9 status read locked", v[3], 1);
    wr(3'd0, 32'h1);
    chk("R9 ctrl no fault", fault_o, 0);
    @(negedge clk_i);
    chk("R9 ctrl ignored", osc_en_o, 0);
    rd(3'd0, v); chk("R9 ctrl value kept", v, 0);
    wr(3'd1, cfg_word(2'd1, 1'b1, 12'd9));
    chk("R9 cfg no fault", fault_o, 0);
    rd(3'd1, v); chk("R9 cfg kept", v, cfg_word(2'd2, 1'b0, 12'd5));
    wr(3'd2, 32'h77);
    chk("R9 cal ignored", cal_tune_o, 8'h33);
    wr(3'd4, 32'h1A21);
    rd(3'd4, v); chk("R8 near key locks", v, 1);
    wr(3'd4, 32'h1A20);
    rd(3'd4, v); chk("R8 unlocked", v, 0);
    wr(3'd0, 32'h1);
    @(negedge clk_i);
    chk("R8 ctrl works after unlock", osc_en_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule